// File: doc/BRIEF.md
# Modem Control Register with Loopback Routing

This block keeps the modem-control byte of a serial port and sits between the port's transmitter/receiver core and the device pins. Software writes the byte. Its four low bits assert the four modem handshake outputs, and a fifth bit switches the block into a self-test loopback mode. The block also presents the four incoming handshake lines to the status logic as active-high signals.

In normal mode, serial data and handshake lines pass straight through. The pin outputs use active-low signalling and the status side uses active-high signalling. In loopback mode the pins are cut off. The external serial output idles at marking, and the external serial input and handshake inputs are ignored. The transmitter output drives the receiver input directly. Each of the four control bits appears on one of the four status lines, so one write can test the handshake path end to end.

Top module: `modem_ctl_loop`

## Requirements
- R1: After reset, the control byte reads 0x00 and all four modem output pins sit at their inactive level (1). Loopback is off, so the serial pins pass through.
- R2: A write with `wr_en` high stores `wr_data[4:0]` at the next rising clock edge. Bits 7:5 always read 0, whatever value was written to them.
- R3: In normal mode, bit 0 drives `pin_dtr_n`, bit 1 drives `pin_rts_n`, bit 2 drives `pin_out1_n` and bit 3 drives `pin_out2_n`. A bit value of 1 puts its pin low (active).
- R4: In normal mode, `stat_dsr`, `stat_cts`, `stat_ri` and `stat_dcd` equal the inverse of `pin_dsr_n`, `pin_cts_n`, `pin_ri_n` and `pin_dcd_n` respectively.
- R5: In normal mode, `pin_tx` equals `core_tx` and `core_rx` equals `pin_rx`.
- R6: When bit 4 is 1 (loopback), `pin_tx` is held at 1, `core_rx` equals `core_tx`, and `pin_rx` has no effect.
- R7: In loopback, all four modem output pins are held at 1, whatever bits 3:0 hold.
- R8: In loopback, `stat_dsr` equals bit 0, `stat_cts` equals bit 1, `stat_ri` equals bit 2 and `stat_dcd` equals bit 3. The four external handshake inputs have no effect.
- R9: In a cycle with `wr_en` low, the stored byte does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value to write |
| rd_data | output | 8 | Current control byte, reserved bits zero |
| core_tx | input | 1 | Serial output of the transmitter core |
| core_rx | output | 1 | Serial input to the receiver core |
| pin_tx | output | 1 | Serial output pin |
| pin_rx | input | 1 | Serial input pin |
| pin_dtr_n | output | 1 | Data-terminal-ready pin, active low |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| pin_out1_n | output | 1 | Auxiliary output 1 pin, active low |
| pin_out2_n | output | 1 | Auxiliary output 2 pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_ri_n | input | 1 | Ring-indicator pin, active low |
| pin_dcd_n | input | 1 | Carrier-detect pin, active low |
| stat_dsr | output | 1 | Data-set-ready to status logic, active high |
| stat_cts | output | 1 | Clear-to-send to status logic, active high |
| stat_ri | output | 1 | Ring indicator to status logic, active high |
| stat_dcd | output | 1 | Carrier detect to status logic, active high |

## Verification
A single write can switch the loopback bit and change the control bits in the same clock edge. In that cycle, live serial traffic and external handshake activity must be rerouted or dropped immediately. Random writes are therefore interleaved with pin and transmitter values that change every cycle, and some writes toggle bit 4 while the other bits also change. Each cycle, the outputs are compared with a model computed from the byte the bench itself tracks. A stale mux select or a stale control value shows up as a mismatch in the first cycle after the write.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
   localparam int N_HS      = 4;
   localparam int B_DTR     = 0;
   localparam int B_RTS     = 1;
   localparam int B_OUT1    = 2;
   localparam int B_OUT2    = 3;
   localparam int B_LOOP    = 4;
   localparam int USED_BITS = 5;

   typedef logic [N_HS-1:0] hs_vec_t;

   function automatic logic [31:0] used_mask(input int w);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < USED_BITS && i < w; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/mcl_reg.sv
module mcl_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import mcl_pkg::*;
   localparam logic [31:0] MASK32 = used_mask(W);
   localparam logic [W-1:0] MASK  = MASK32[W-1:0];

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q[i] <= 1'b0;
            else if (we) q[i] <= d[i];
         end
      end else begin : g_rsvd
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/mcl_pol.sv
module mcl_pol #(
   parameter int N          = 4,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [N-1:0] a,
   output logic [N-1:0] y
);
   if (ACTIVE_LOW) begin : g_inv
      assign y = ~a;
   end else begin : g_pass
      assign y = a;
   end
endmodule

// File: rtl/mcl_route.sv
module mcl_route (
   input  logic             lb,
   input  logic             core_tx,
   input  logic             pin_rx,
   input  mcl_pkg::hs_vec_t ctl,
   input  mcl_pkg::hs_vec_t ext_sts,
   output logic             pin_tx,
   output logic             core_rx,
   output mcl_pkg::hs_vec_t ctl_drv,
   output mcl_pkg::hs_vec_t sts
);
   always_comb begin
      if (lb) begin
         pin_tx  = 1'b1;
         core_rx = core_tx;
         ctl_drv = '0;
         sts     = ctl;
      end else begin
         pin_tx  = core_tx;
         core_rx = pin_rx;
         ctl_drv = ctl;
         sts     = ext_sts;
      end
   end
endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop #(
   parameter int REG_W          = 8,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             core_tx,
   output logic             core_rx,
   output logic             pin_tx,
   input  logic             pin_rx,
   output logic             pin_dtr_n,
   output logic             pin_rts_n,
   output logic             pin_out1_n,
   output logic             pin_out2_n,
   input  logic             pin_dsr_n,
   input  logic             pin_cts_n,
   input  logic             pin_ri_n,
   input  logic             pin_dcd_n,
   output logic             stat_dsr,
   output logic             stat_cts,
   output logic             stat_ri,
   output logic             stat_dcd
);
   import mcl_pkg::*;

   if (REG_W < USED_BITS) begin : g_bad_width
      $error("modem_ctl_loop: REG_W must be at least %0d", USED_BITS);
   end

   logic [REG_W-1:0] ctl_q;
   hs_vec_t          ctl_drv, pin_out_lvl, pin_in_lvl, ext_sts, sts;

   mcl_reg #(.W(REG_W)) u_reg (
      .clk (clk),
      .rst_n (rst_n),
      .we  (wr_en),
      .d   (wr_data),
      .q   (ctl_q)
   );

   assign pin_in_lvl = {pin_dcd_n, pin_ri_n, pin_cts_n, pin_dsr_n};

   mcl_pol #(.N(N_HS), .ACTIVE_LOW(PIN_ACTIVE_LOW)) u_pol_in (
      .a (pin_in_lvl),
      .y (ext_sts)
   );

   mcl_route u_route (
      .lb      (ctl_q[B_LOOP]),
      .core_tx (core_tx),
      .pin_rx  (pin_rx),
      .ctl     (ctl_q[N_HS-1:0]),
      .ext_sts (ext_sts),
      .pin_tx  (pin_tx),
      .core_rx (core_rx),
      .ctl_drv (ctl_drv),
      .sts     (sts)
   );

   mcl_pol #(.N(N_HS), .ACTIVE_LOW(PIN_ACTIVE_LOW)) u_pol_out (
      .a (ctl_drv),
      .y (pin_out_lvl)
   );

   assign pin_dtr_n  = pin_out_lvl[B_DTR];
   assign pin_rts_n  = pin_out_lvl[B_RTS];
   assign pin_out1_n = pin_out_lvl[B_OUT1];
   assign pin_out2_n = pin_out_lvl[B_OUT2];

   assign stat_dsr = sts[B_DTR];
   assign stat_cts = sts[B_RTS];
   assign stat_ri  = sts[B_OUT1];
   assign stat_dcd = sts[B_OUT2];

   assign rd_data = ctl_q;
endmodule

// File: rtl/mcl_checker.sv
module mcl_checker #(
   parameter int REG_W          = 8,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             core_tx,
   input logic             core_rx,
   input logic             pin_tx,
   input logic             pin_rx,
   input logic             pin_dtr_n,
   input logic             pin_rts_n,
   input logic             pin_out1_n,
   input logic             pin_out2_n,
   input logic             stat_dsr,
   input logic             stat_cts,
   input logic             stat_ri,
   input logic             stat_dcd
);
   localparam logic [REG_W-1:0] LIVE = REG_W'(5'h1F);
   localparam logic             IDLE = PIN_ACTIVE_LOW;

   logic seen;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;

   logic lb;
   assign lb = rd_data[4];

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE) == '0);
   p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $past(wr_en) |-> rd_data == ($past(wr_data) & LIVE));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !$past(wr_en) |-> $stable(rd_data));
   p_norm_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lb |-> {pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n} ==
              (rd_data[3:0] ^ {4{PIN_ACTIVE_LOW}}));
   p_norm_serial_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lb |-> (pin_tx == core_tx) && (core_rx == pin_rx));
   p_lb_serial_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lb |-> pin_tx && (core_rx == core_tx));
   p_lb_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lb |-> {pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n} == {4{IDLE}});
   p_lb_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lb |-> {stat_dcd, stat_ri, stat_cts, stat_dsr} == rd_data[3:0]);
endmodule

bind modem_ctl_loop mcl_checker #(.REG_W(REG_W), .PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)) u_chk (.*);

// File: tb/modem_ctl_loop_bench.sv
module modem_ctl_loop_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       core_tx = 1'b1;
   logic       pin_rx = 1'b1;
   logic [3:0] sin_n = 4'hF;
   logic [7:0] rd_data;
   logic       core_rx, pin_tx;
   logic       pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n;
   logic       stat_dsr, stat_cts, stat_ri, stat_dcd;

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] mreg = '0;

   always #(CLK_P/2) clk = ~clk;

   modem_ctl_loop u_modem_ctl_loop (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .core_tx(core_tx), .core_rx(core_rx), .pin_tx(pin_tx), .pin_rx(pin_rx),
      .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n), .pin_out1_n(pin_out1_n),
      .pin_out2_n(pin_out2_n), .pin_dsr_n(sin_n[0]), .pin_cts_n(sin_n[1]),
      .pin_ri_n(sin_n[2]), .pin_dcd_n(sin_n[3]), .stat_dsr(stat_dsr),
      .stat_cts(stat_cts), .stat_ri(stat_ri), .stat_dcd(stat_dcd)
   );

   function automatic logic [7:0] stored(input logic [7:0] d);
      return d & 8'h1F;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      logic [3:0] pins, stat;
      pins = {pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n};
      stat = {stat_dcd, stat_ri, stat_cts, stat_dsr};
      chk("R2", "rd_data", rd_data, mreg);
      if (mreg[4]) begin
         chk("R6", "pin_tx", {7'd0, pin_tx}, 8'd1);
         chk("R6", "core_rx", {7'd0, core_rx}, {7'd0, core_tx});
         chk("R7", "pins", {4'd0, pins}, 8'h0F);
         chk("R8", "stat", {4'd0, stat}, {4'd0, mreg[3:0]});
      end else begin
         chk("R5", "pin_tx", {7'd0, pin_tx}, {7'd0, core_tx});
         chk("R5", "core_rx", {7'd0, core_rx}, {7'd0, pin_rx});
         chk("R3", "pins", {4'd0, pins}, {4'd0, ~mreg[3:0]});
         chk("R4", "stat", {4'd0, stat}, {4'd0, ~sin_n});
      end
   endtask

   task automatic step(input logic we, input logic [7:0] d, input logic tx,
                       input logic rx, input logic [3:0] s);
      wr_en = we; wr_data = d; core_tx = tx; pin_rx = rx; sin_n = s;
      #1;
      check_all();
      @(posedge clk);
      if (we) mreg = stored(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      @(negedge clk);
      #1;
      // R1: reset state
      chk("R1", "rd_data", rd_data, 8'h00);
      chk("R1", "pins", {4'd0, pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n}, 8'h0F);
      core_tx = 1'b0; #1;
      chk("R1", "pin_tx", {7'd0, pin_tx}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reserved bits dropped
      step(1'b1, 8'hFF, 1'b0, 1'b1, 4'h0);
      step(1'b0, 8'hE0, 1'b1, 1'b0, 4'h5);
      chk("R2", "rsvd", rd_data & 8'hE0, 8'h00);
      // R9: holds without strobe while data bus moves
      step(1'b0, 8'h00, 1'b0, 1'b1, 4'hA);
      chk("R9", "hold", rd_data, 8'h1F);
      // R8: loopback ignores external handshake
      step(1'b1, 8'h15, 1'b1, 1'b0, 4'h0);
      step(1'b0, 8'h00, 1'b0, 1'b0, 4'hF);
      chk("R8", "stat_dsr", {7'd0, stat_dsr}, 8'd1);
      chk("R8", "stat_cts", {7'd0, stat_cts}, 8'd0);
      // R6: external rx ignored in loopback
      step(1'b0, 8'h00, 1'b1, 1'b0, 4'h3);
      chk("R6", "core_rx", {7'd0, core_rx}, 8'd1);
      // R3: all outputs active in normal mode
      step(1'b1, 8'h0F, 1'b1, 1'b1, 4'hC);
      step(1'b0, 8'h00, 1'b0, 1'b1, 4'h9);
      chk("R3", "all_active", {4'd0, pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n}, 8'h00);
      // R7: same bits with loopback forces pins idle
      step(1'b1, 8'h1F, 1'b0, 1'b1, 4'h6);
      step(1'b0, 8'h00, 1'b1, 1'b0, 4'h6);
      chk("R7", "forced_idle", {4'd0, pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n}, 8'h0F);

      for (int i = 0; i < 3000; i++) begin
         logic we;
         logic [7:0] d;
         we = (($urandom % 3) == 0);
         d  = 8'($urandom);
         step(we, d, 1'($urandom), 1'($urandom), 4'($urandom));
      end

      summary();
      $finish;
   end
endmodule